// File: doc/BRIEF.md
# UART Two-Stage Baud Tick Generator

This block derives the timing strobes for a serial transmitter and receiver from a single reference clock. The reference clock can first be slowed by a fixed factor of eight, then a 16-bit clock divisor turns the selected clock into a sample strobe, and an 8-bit bit divider counts a programmable number of sample strobes to mark each bit period. The bit rate is therefore the selected clock divided by CD times (BDIV + 1).

Software picks the divisor values and loads them, with the prescaler choice, through a one-cycle configuration write. Every write restarts all counting, so the first strobe after a change arrives one full period later. A divisor below 2 parks the block with both strobes low, and dropping the enable holds all counters at zero. Both strobes are one reference-clock cycle wide.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and until a configuration is written, sample_tick and bit_tick stay low (the loaded divisor resets to 0).
- R2: When the loaded divisor cfg_cd is 0 or 1, both strobes stay low regardless of enable.
- R3: With cfg_presc = 0 and divisor CD (2..65535), sample_tick pulses every CD cycles, the first in the CD-th cycle after the configuration write.
- R4: With cfg_presc = 1, sample_tick pulses every 8 × CD cycles, the first in the (8 × CD)-th cycle after the write.
- R5: bit_tick pulses together with every (BDIV + 1)-th sample_tick counted from the last restart, and never without a sample_tick.
- R6: A cycle with cfg_wr high loads cfg_presc, cfg_cd and cfg_bdiv, shows no strobe, and restarts both counters so the next periods are counted from the following cycle.
- R7: While enable is low both strobes are low and all counters are held at zero; counting restarts from zero in the first cycle enable is high again.
- R8: The extreme settings CD = 65535 and BDIV = 254 produce the periods given by R3 and R5.
- R9: Each strobe is one cycle wide: a sample_tick is never followed by a sample_tick in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run enable; low holds all counters at zero |
| cfg_wr | input | 1 | One-cycle strobe loading the three configuration fields |
| cfg_presc | input | 1 | 1 selects the reference clock divided by 8 |
| cfg_cd | input | 16 | Clock divisor producing the sample strobe |
| cfg_bdiv | input | 8 | Bit divider; bit period is cfg_bdiv + 1 sample strobes |
| sample_tick | output | 1 | One-cycle sample strobe |
| bit_tick | output | 1 | One-cycle bit-period strobe |

## Verification
The hardest situation to reach is the interplay of a restart with a half-finished period: a configuration write or an enable drop arriving when the prescaler, sample and bit counters are all part-way through their counts. The stimulus rewrites the same values mid-period, switches the prescaler on in the middle of a run, and drops enable between strobes, while a reference model counting cycles since the last restart predicts each strobe. The widest divisor is reached by running a full 65535-cycle sample period.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned PRESC_RATIO = 8;
  typedef enum logic {
    CLK_DIRECT = 1'b0,
    CLK_SLOWED = 1'b1
  } clk_sel_e;
endpackage

// File: rtl/baud_presc.sv
module baud_presc
  import baud_pkg::*;
#(
  parameter int unsigned RATIO = PRESC_RATIO
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  clk_sel_e sel,
  output logic     sel_en
);
  localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr || cnt_q == LAST) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sel_en = (sel == CLK_DIRECT) ? 1'b1 : (cnt_q == LAST);
endmodule

// File: rtl/baud_cnt.sv
module baud_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_end;

  assign at_end = (cnt_q == limit);
  assign wrap   = step && at_end && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (step) begin
      if (at_end)      cnt_d = '0;
      else             cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned CD_W   = 16,
  parameter int unsigned BDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic              cfg_presc,
  input  logic [CD_W-1:0]   cfg_cd,
  input  logic [BDIV_W-1:0] cfg_bdiv,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam logic [CD_W-1:0] CD_MIN = CD_W'(2);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  clk_sel_e          presc_q;
  logic [CD_W-1:0]   cd_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic              cd_ok, restart, run;
  logic              sel_en, samp_wrap, bit_wrap;
  logic [CD_W-1:0]   cd_last;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration registers, loaded by the write strobe
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      presc_q <= CLK_DIRECT;
      cd_q    <= '0;
      bdiv_q  <= '0;
    end else if (cfg_wr) begin
      presc_q <= clk_sel_e'(cfg_presc);
      cd_q    <= cfg_cd;
      bdiv_q  <= cfg_bdiv;
    end
  end

  assign cd_ok   = (cd_q >= CD_MIN);
  assign restart = cfg_wr || !enable;
  assign run     = enable && !cfg_wr && cd_ok;
  assign cd_last = cd_q - 1'b1;

  baud_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (restart),
    .sel    (presc_q),
    .sel_en (sel_en)
  );

  baud_cnt #(.W(CD_W)) u_samp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (restart || !cd_ok),
    .step  (sel_en),
    .limit (cd_last),
    .wrap  (samp_wrap)
  );

  assign sample_tick = run && samp_wrap;

  baud_cnt #(.W(BDIV_W)) u_bit (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (restart || !cd_ok),
    .step  (sample_tick),
    .limit (bdiv_q),
    .wrap  (bit_wrap)
  );

  assign bit_tick = sample_tick && bit_wrap;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int unsigned CD_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            cfg_wr,
  input logic [CD_W-1:0] cd_q,
  input logic            sample_tick,
  input logic            bit_tick
);
  // R9
  samp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  // R5
  bit_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!sample_tick && !bit_tick));

  // R6
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (!sample_tick && !bit_tick));

  // R2
  small_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q < CD_W'(2)) |-> !sample_tick);
endmodule

bind baud_tick_gen baud_tick_chk #(.CD_W(CD_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cfg_wr      (cfg_wr),
  .cd_q        (cd_q),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_presc = 1'b0;
  logic [15:0] cfg_cd = '0;
  logic [7:0]  cfg_bdiv = '0;
  logic        sample_tick, bit_tick;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    wd = 0;
  string phase = "R1";

  // model state
  longint m_cd = 0, m_bdiv = 0, el = 0;
  bit     m_presc = 0;

  always #10 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_presc(cfg_presc), .cfg_cd(cfg_cd), .cfg_bdiv(cfg_bdiv),
    .sample_tick(sample_tick), .bit_tick(bit_tick));

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // model update: cycles elapsed since the last restart
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cd = 0; m_bdiv = 0; m_presc = 0; el = 0;
    end else if (cfg_wr) begin
      m_cd = cfg_cd; m_bdiv = cfg_bdiv; m_presc = cfg_presc; el = 0;
    end else if (!enable) el = 0;
    else el = el + 1;
    wd = wd + 1;
    if (wd > 200000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    longint per;
    bit act, es, eb;
    per = m_cd * (m_presc ? 8 : 1);
    act = rst_n && enable && !cfg_wr && (m_cd >= 2);
    es  = act && (((el + 1) % per) == 0);
    eb  = act && (((el + 1) % (per * (m_bdiv + 1))) == 0);
    n_cmp = n_cmp + 1;
    if (sample_tick !== es || bit_tick !== eb) begin
      n_bad = n_bad + 1;
      $display("FAIL %s t=%0t: actual sample=%b bit=%b expected sample=%b bit=%b",
               phase, $time, sample_tick, bit_tick, es, eb);
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cfg(input bit p, input int cd, input int bd);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_presc = p; cfg_cd = 16'(cd); cfg_bdiv = 8'(bd);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  initial begin
    // R1: reset and idle after release
    phase = "R1";
    run(5); #1; rst_n = 1'b1;
    run(10);
    enable = 1'b1;
    run(10);
    // R2: divisors 0 and 1 keep the strobes low
    phase = "R2";
    cfg(0, 0, 4); run(50);
    cfg(0, 1, 4); run(50);
    // R3: direct clock
    phase = "R3";
    cfg(0, 4, 4); run(100);
    cfg(0, 2, 5); run(60);
    // R4: slowed clock
    phase = "R4";
    cfg(1, 3, 4); run(400);
    // R5: bit divider
    phase = "R5";
    cfg(0, 5, 9); run(200);
    // R6: restart mid-period, same and new values
    phase = "R6";
    cfg(0, 6, 4); run(23);
    cfg(0, 6, 4); run(50);
    cfg(1, 2, 4); run(37);
    cfg(0, 3, 2); run(40);
    // R7: enable drop mid-period
    phase = "R7";
    run(7); #1; enable = 1'b0;
    run(20); #1; enable = 1'b1;
    run(100);
    #1; enable = 1'b0; run(3); #1; enable = 1'b1;
    run(50);
    // R8: range extremes
    phase = "R8";
    cfg(0, 2, 254); run(1100);
    cfg(0, 65535, 4); run(65600);
    finish_run();
  end
endmodule